// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between up to six external interrupt pins and an interrupt controller. Each pin is first brought into the clock domain by a synchroniser. It is then judged against its own trigger type: rising edge, falling edge, either edge, high level or low level. The result is held in a per-input status bit. The status bit is gated by a per-input enable, and the gated result leaves the block as a registered request line.

Software programs the block through four 32-bit words on a simple single-cycle bus. A packed word holds one 3-bit trigger code per input at a 4-bit stride. A second word is a per-input initial-condition setting. A third word is the status word, which is cleared by writing zeros. A fourth word holds the enables. After reset every input is configured as active-low level and every enable is off, so no request leaves the block until software enables an input. Prioritising among the requests is done downstream.

Top module: `exti_unit`

## Requirements
- R1: After reset the configuration word reads 0x00666666 (code 6, active-low level, on all six inputs). The initial-condition, status and enable words read 0, and every request output is 0.
- R2: The trigger code of input i occupies configuration bits [4i+2:4i] at byte offset 0x0. Bit 4i+3 and every bit above the last field always read 0, whatever was written.
- R3: With code 1 (rising), status bit i becomes 1 three clock edges after a 0-to-1 change of pin i is first sampled. Code 1 ignores falling changes.
- R4: Code 2 (falling) sets status on a 1-to-0 change only. Code 3 sets status on either change. Both have the same three-edge latency.
- R5: For codes 1 to 3 the status bit holds until a write to offset 0x8 places a 0 in bit i. A written 1 leaves the bit unchanged. If a new edge arrives in the same cycle as the clearing write, the edge wins and the bit stays 1.
- R6: With code 5 the status bit follows the synchronised pin. With code 6 it follows the inverse of the synchronised pin. A clearing write has no lasting effect while the level is active.
- R7: Codes 0, 4 and 7 never set a status bit. Switching an input to one of these codes drops its pending bit on the next edge.
- R8: Request output i is a register loaded with status bit i AND enable bit i, where enable bit i is at offset 0xC. Clearing the enable bit removes the request one edge after the write, and the status bit is left as it was.
- R9: The initial-condition word at offset 0x4 stores one bit per input, reads back what was written, and does not change detection or requests.
- R10: A read returns the addressed word in the same cycle. Bits above the implemented inputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| ext_pin | input | 6 | Asynchronous external interrupt pins |
| irq_req | output | 6 | Registered per-input requests |

## Verification
A status bit that holds a wrong value shows up at the request outputs one edge later, provided the input is enabled. It can also be seen right away by reading the status word. A faulty synchroniser or edge history moves the request by whole cycles, or creates or drops a request. The bench checks the exact edge at which each change is allowed. A per-cycle behavioural model of the request lines catches any such difference on the first clock where the lines disagree, across directed cases and a randomised run of pins and register writes.

// File: rtl/exti_pkg.sv
package exti_pkg;

   localparam int CODE_W       = 3;
   localparam int FIELD_STRIDE = 4;
   localparam int MAX_INPUTS   = 6;
   localparam int BUS_W        = 32;

   typedef enum logic [CODE_W-1:0] {
      TRG_OFF  = 3'd0,
      TRG_RISE = 3'd1,
      TRG_FALL = 3'd2,
      TRG_BOTH = 3'd3,
      TRG_RSV4 = 3'd4,
      TRG_HIGH = 3'd5,
      TRG_LOW  = 3'd6,
      TRG_RSV7 = 3'd7
   } trig_e;

   typedef enum logic [1:0] {
      WSEL_TYPE   = 2'd0,
      WSEL_INIT   = 2'd1,
      WSEL_STATUS = 2'd2,
      WSEL_ENABLE = 2'd3
   } wsel_e;

   function automatic logic is_edge_mode(trig_e t);
      return (t == TRG_RISE) || (t == TRG_FALL) || (t == TRG_BOTH);
   endfunction

   function automatic logic is_level_mode(trig_e t);
      return (t == TRG_HIGH) || (t == TRG_LOW);
   endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
   parameter int   WIDTH   = 6,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_VAL}};

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("exti_sync: at least two stages are required");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VEC;
               else        chain_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VEC;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/exti_detect.sv
module exti_detect
   import exti_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sync_i,
   input  trig_e trig_i,
   input  logic  clr_i,
   output logic  status_o
);

   logic prev_q;
   logic st_q;
   logic st_d;
   logic rise;
   logic fall;
   logic evt;
   logic edge_mode;
   logic lvl_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_i;
   end

   always_comb begin
      rise      = sync_i & ~prev_q;
      fall      = ~sync_i & prev_q;
      edge_mode = is_edge_mode(trig_i);
      lvl_mode  = is_level_mode(trig_i);
      unique case (trig_i)
         TRG_RISE: evt = rise;
         TRG_FALL: evt = fall;
         TRG_BOTH: evt = rise | fall;
         default:  evt = 1'b0;
      endcase
   end

   always_comb begin
      if (edge_mode)               st_d = (st_q & ~clr_i) | evt;
      else if (trig_i == TRG_HIGH) st_d = sync_i;
      else if (trig_i == TRG_LOW)  st_d = ~sync_i;
      else                         st_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= st_d;
   end

   assign status_o = st_q;

   a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && st_q && !clr_i) |=> st_q);

   a_r5_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && clr_i && !evt) |=> !st_q);

   a_r6_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i == TRG_HIGH) |=> (st_q == $past(sync_i)));

   a_r7_quiet_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && !lvl_mode) |=> !st_q);

endmodule

// File: rtl/exti_regs.sv
module exti_regs
   import exti_pkg::*;
#(
   parameter int NUM_IN = 6,
   parameter int ADDR_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sel_i,
   input  logic                            wr_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [BUS_W-1:0]                wdata_i,
   output logic [BUS_W-1:0]                rdata_o,
   input  logic [NUM_IN-1:0]               status_i,
   output logic [NUM_IN-1:0][CODE_W-1:0]   cfg_o,
   output logic [NUM_IN-1:0]               en_o,
   output logic [NUM_IN-1:0]               clr_o
);

   localparam int HI_W = ADDR_W - 4;

   logic [NUM_IN-1:0][CODE_W-1:0] cfg_q;
   logic [NUM_IN-1:0]             init_q;
   logic [NUM_IN-1:0]             en_q;
   wsel_e                         wsel;
   logic                          hit;
   logic                          wr_hit;
   logic [1:0]                    unused_addr;

   assign wsel        = wsel_e'(addr_i[3:2]);
   assign unused_addr = addr_i[1:0];

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("exti_regs: address must be at least 4 bits");
      end
      if (HI_W > 0) begin : g_hi_dec
         assign hit = (addr_i[ADDR_W-1:4] == '0);
      end else begin : g_no_hi
         assign hit = 1'b1;
      end
   endgenerate

   assign wr_hit = sel_i && wr_i && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_IN; i++) cfg_q[i] <= TRG_LOW;
         init_q <= '0;
         en_q   <= '0;
      end else if (wr_hit) begin
         unique case (wsel)
            WSEL_TYPE:
               for (int i = 0; i < NUM_IN; i++)
                  cfg_q[i] <= wdata_i[FIELD_STRIDE*i +: CODE_W];
            WSEL_INIT:   init_q <= wdata_i[NUM_IN-1:0];
            WSEL_ENABLE: en_q   <= wdata_i[NUM_IN-1:0];
            default: ;
         endcase
      end
   end

   assign clr_o = (wr_hit && wsel == WSEL_STATUS) ? ~wdata_i[NUM_IN-1:0] : '0;
   assign cfg_o = cfg_q;
   assign en_o  = en_q;

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         unique case (wsel)
            WSEL_TYPE:
               for (int i = 0; i < NUM_IN; i++)
                  rdata_o[FIELD_STRIDE*i +: CODE_W] = cfg_q[i];
            WSEL_INIT:   rdata_o[NUM_IN-1:0] = init_q;
            WSEL_STATUS: rdata_o[NUM_IN-1:0] = status_i;
            WSEL_ENABLE: rdata_o[NUM_IN-1:0] = en_q;
            default: ;
         endcase
      end
   end

   a_r8_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wsel == WSEL_ENABLE) |=> (en_q == $past(wdata_i[NUM_IN-1:0])));

   a_r9_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && wsel == WSEL_INIT) |=> $stable(init_q));

endmodule

// File: rtl/exti_unit.sv
module exti_unit
   import exti_pkg::*;
#(
   parameter int NUM_IN      = 6,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_IN-1:0] ext_pin,
   output logic [NUM_IN-1:0] irq_req
);

   generate
      if (NUM_IN < 1 || NUM_IN > MAX_INPUTS) begin : g_bad_count
         $error("exti_unit: NUM_IN must lie between 1 and 6");
      end
   endgenerate

   logic [NUM_IN-1:0]             pin_sync;
   logic [NUM_IN-1:0][CODE_W-1:0] cfg_w;
   logic [NUM_IN-1:0]             en_w;
   logic [NUM_IN-1:0]             clr_w;
   logic [NUM_IN-1:0]             status_w;
   logic [NUM_IN-1:0]             irq_q;

   exti_sync #(
      .WIDTH   (NUM_IN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_pin),
      .sync_o  (pin_sync)
   );

   exti_regs #(
      .NUM_IN (NUM_IN),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (bus_sel),
      .wr_i     (bus_wr),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .rdata_o  (bus_rdata),
      .status_i (status_w),
      .cfg_o    (cfg_w),
      .en_o     (en_w),
      .clr_o    (clr_w)
   );

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
         exti_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (pin_sync[i]),
            .trig_i   (trig_e'(cfg_w[i])),
            .clr_i    (clr_w[i]),
            .status_o (status_w[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= status_w & en_w;
   end

   assign irq_req = irq_q;

   a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_q & ~$past(en_w)) == '0));

   a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_w) == '0) |-> (irq_q == '0));

endmodule

// File: tb/exti_unit_bench.sv
module exti_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [3:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [5:0]  ext_pin, irq_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   exti_unit u_exti_unit (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_pin(ext_pin), .irq_req(irq_req)
   );

   // behavioural reference of the request lines
   logic [5:0]  m_s1 = 6'h3F, m_s2 = 6'h3F, m_prev = 6'h3F;
   logic [5:0]  m_st = '0, m_en = '0, m_irq = '0;
   logic [31:0] m_cfg = 32'h00666666;

   always @(posedge clk) begin
      logic [5:0] st_n;
      logic [2:0] code;
      logic       r, f, ev, clr, wh;
      if (!rst_n) begin
         m_s1 = 6'h3F; m_s2 = 6'h3F; m_prev = 6'h3F;
         m_st = '0; m_en = '0; m_irq = '0; m_cfg = 32'h00666666;
      end else begin
         wh = bus_sel && bus_wr;
         for (int i = 0; i < 6; i++) begin
            code = m_cfg[4*i +: 3];
            r    = m_s2[i] && !m_prev[i];
            f    = !m_s2[i] && m_prev[i];
            clr  = wh && (bus_addr == 4'h8) && !bus_wdata[i];
            ev   = (code == 3'd1) ? r : (code == 3'd2) ? f : (code == 3'd3) ? (r || f) : 1'b0;
            if (code >= 3'd1 && code <= 3'd3) st_n[i] = (m_st[i] && !clr) || ev;
            else if (code == 3'd5)            st_n[i] = m_s2[i];
            else if (code == 3'd6)            st_n[i] = !m_s2[i];
            else                              st_n[i] = 1'b0;
         end
         m_irq = m_st & m_en;
         m_st  = st_n;
         if (wh && bus_addr == 4'h0) m_cfg = bus_wdata & 32'h00777777;
         if (wh && bus_addr == 4'hC) m_en  = bus_wdata[5:0];
         m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq_req !== m_irq) begin
            fails++;
            $display("FAIL R8 irq vs model act=%h exp=%h", irq_req, m_irq);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h8;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
      bus_addr = 4'h8;
   endtask

   task automatic after_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic report;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
   endtask

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h8;
      bus_wdata = '0; ext_pin = 6'h3F;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      peek(4'h0, v); chk("R1 cfg reset", v, 32'h00666666);
      peek(4'h4, v); chk("R1 init reset", v, 32'h0);
      peek(4'h8, v); chk("R1 status reset", v, 32'h0);
      peek(4'hC, v); chk("R1 enable reset", v, 32'h0);
      chk("R1 irq reset", {26'h0, irq_req}, 32'h0);

      wr(4'h0, 32'hFFFF_FFFF);
      peek(4'h0, v); chk("R2 spare bits", v, 32'h00777777);
      // ch0 rise, ch1 fall, ch2 both, ch3 high, ch4 low, ch5 reserved 4
      wr(4'h0, 32'h00465321);
      peek(4'h0, v); chk("R2 field layout", v, 32'h00465321);
      wr(4'hC, 32'h3F);

      @(negedge clk); ext_pin = 6'h38;
      after_edges(3);
      peek(4'h8, v); chk("R4 falling and both set, R3 rise ignores fall", {29'h0, v[2:0]}, 32'h6);
      wr(4'h8, 32'h0);
      peek(4'h8, v); chk("R5 clear by zero", {29'h0, v[2:0]}, 32'h0);

      @(negedge clk); ext_pin = 6'h3F;
      after_edges(2);
      peek(4'h8, v); chk("R3 not before third edge", {31'h0, v[0]}, 32'h0);
      after_edges(1);
      peek(4'h8, v); chk("R3 rise and R4 both set", {29'h0, v[2:0]}, 32'h5);
      chk("R8 request one edge later", {31'h0, irq_req[0]}, 32'h0);
      after_edges(1);
      chk("R8 request raised", {29'h0, irq_req[2:0]}, 32'h5);

      wr(4'h8, 32'hFFFF_FFFE);
      peek(4'h8, v); chk("R5 written one keeps bit", {29'h0, v[2:0]}, 32'h4);

      // falling edge on ch1 coincides with a clearing write
      @(negedge clk); ext_pin[1] = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      peek(4'h8, v); chk("R5 edge beats clear, R6 level survives clear", {26'h0, v[5:0]}, 32'h0A);

      @(negedge clk); ext_pin[3] = 1'b0; ext_pin[4] = 1'b0;
      after_edges(3);
      peek(4'h8, v); chk("R6 high drops, low rises", {29'h0, v[5:3]}, 32'h2);

      for (int k = 0; k < 4; k++) begin
         @(negedge clk); ext_pin[5] = ~ext_pin[5];
         after_edges(3);
         peek(4'h8, v); chk("R7 reserved code 4 quiet", {31'h0, v[5]}, 32'h0);
      end

      @(negedge clk); ext_pin[0] = 1'b0;
      after_edges(3);
      @(negedge clk); ext_pin[0] = 1'b1;
      after_edges(3);
      peek(4'h8, v); chk("R3 pending before code change", {31'h0, v[0]}, 32'h1);
      wr(4'h0, 32'h00465327);
      after_edges(1);
      peek(4'h8, v); chk("R7 code 7 drops pending", {31'h0, v[0]}, 32'h0);

      @(negedge clk); ext_pin[3] = 1'b1;
      after_edges(4);
      chk("R8 level request on", {31'h0, irq_req[3]}, 32'h1);
      wr(4'hC, 32'h37);
      after_edges(1);
      chk("R8 disable removes request", {31'h0, irq_req[3]}, 32'h0);
      peek(4'h8, v); chk("R8 status kept when disabled", {31'h0, v[3]}, 32'h1);

      wr(4'h4, 32'hFFFF_FFFF);
      peek(4'h4, v); chk("R9 init readback", v, 32'h3F);
      after_edges(2);
      peek(4'h8, v); chk("R10 upper status bits zero", v & 32'hFFFF_FFC0, 32'h0);
      chk("R9 init leaves requests", {26'h0, irq_req}, {26'h0, m_irq});

      wr(4'hC, 32'h3F);
      for (int c = 0; c < 600; c++) begin
         int r;
         @(negedge clk);
         bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h8;
         r = $urandom_range(0, 15);
         if (r < 3) ext_pin = 6'($urandom);
         else if (r == 3) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = $urandom;
         end else if (r == 4) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = $urandom;
         end else if (r == 5) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = $urandom;
         end
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      after_edges(4);

      done = 1'b1;
      report();
      $finish;
   end

endmodule